// File: doc/BRIEF.md
# Radio Status and Interrupt Register Bank

This block holds the control and status registers for the digital back end of a packet radio. Software reaches it over a simple register bus made of an address, write data and a write strobe. Read data comes back registered, one cycle after the address is presented. The bank has two registers. The control/status register at address 0x0E mixes read/write control bits with sticky event flags. Software clears each sticky flag by writing 1 to its bit. The threshold register at address 0x0F holds an 8-bit signal-strength level.

The block has four status inputs:
- a pulse when the start pattern is recognized,
- a pulse when the last transmit bit has been handed to the modulator,
- a pulse on FIFO overflow,
- the raw PLL lock level, which is synchronized inside the block.

It compares a live 8-bit RSSI sample against the threshold. It drives four outputs:
- a one-cycle FIFO clear pulse,
- the FIFO fill enable,
- a lock indicator pin,
- an interrupt line.

A fill-mode bit chooses how the fill enable behaves. In mode 0 it is a latch armed by the start pattern. In mode 1 it is a level that software writes directly.

Top module: `radio_stat_regs`

## Requirements
- R1: In reset, every output is 0 and rdata is 0. After reset, address 0x0E reads 0x01 (only the lock pin enable is set) and address 0x0F reads 0x00.
- R2: rdata is registered: the value shown one cycle after the address is presented is the register value before that edge. Writes to 0x0F store the threshold. Any address other than 0x0E and 0x0F reads 0 and ignores writes. At 0x0E, bits 7 (fill mode), 3 (RSSI interrupt enable) and 0 (lock pin enable) are plain read/write bits.
- R3: In fill mode 0, a start-pattern pulse sets bit 6 (start detect) from the next cycle, and the bit stays set. Writing 1 to bit 6 clears it. fill_en always equals bit 6.
- R4: In fill mode 1, bit 6 takes the written value on every write to 0x0E, and start-pattern pulses are ignored.
- R5: Bit 5 (transmit done) sets on a last-bit pulse and clears when 1 is written to it.
- R6: Bit 4 (overflow) sets on an overflow pulse. Writing 1 to bit 4 clears the flag and gives fifo_clr=1 for exactly the next cycle.
- R7: When pkt_mode=1, that overflow clear also clears bit 5, and clears bit 6 in fill mode 0. When pkt_mode=0, bits 5 and 6 are left alone.
- R8: Bit 2 (signal detect) sets whenever the RSSI sample is greater than or equal to the threshold. It stays set until 1 is written to it.
- R9: Bit 1 (lock seen) sets once for each rising edge of the synchronized PLL lock, and holding lock high does not set it again. Writing 1 to bit 1 clears it.
- R10: When bit 0 is 0, lock_pin is driven to 1. When bit 0 is 1, lock_pin follows the PLL lock level after the synchronizer, with a latency of SYNC_STAGES+1 cycles.
- R11: irq is 1 exactly when bit 2 and bit 3 are both 1.
- R12: If a set event and a write-1 clear of the same flag fall in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rdata | output | 8 | Registered read data |
| pkt_mode | input | 1 | 1 = packet data mode, 0 = buffered mode |
| start_pat | input | 1 | Start pattern recognized pulse |
| tx_last | input | 1 | Last transmit bit handed over pulse |
| fifo_ovf | input | 1 | FIFO overflow pulse |
| pll_lock | input | 1 | Raw PLL lock level |
| rssi_val | input | 8 | Live RSSI sample |
| fifo_clr | output | 1 | One-cycle FIFO clear pulse |
| fill_en | output | 1 | FIFO fill enable |
| lock_pin | output | 1 | Lock indicator pin |
| irq | output | 1 | Interrupt line |

## Verification
The main clash is a hardware set event and a software write-1 clear of the same flag landing in one cycle. The directed case raises the RSSI above the threshold in the very cycle that software writes 1 to the signal-detect bit, and expects irq to stay high. The random phase fires event pulses and status-register writes independently, so such collisions recur on every flag. A packet-mode overflow clear meeting a start-pattern or last-bit pulse is another collision of this kind. Every cycle is judged against a bench model in which the set event always wins.

// File: rtl/radio_stat_pkg.sv
package radio_stat_pkg;

  typedef struct packed {
    logic fill_mode;
    logic start_det;
    logic tx_done;
    logic ovf;
    logic rssi_ien;
    logic sig_det;
    logic lock_seen;
    logic lock_en;
  } stat_reg_t;

  localparam logic [7:0] STAT_RESET = 8'h01;

  localparam int FLG_TX   = 0;
  localparam int FLG_OVF  = 1;
  localparam int FLG_SIG  = 2;
  localparam int FLG_LOCK = 3;
  localparam int NUM_FLG  = 4;

endpackage

// File: rtl/sticky_flag.sv
module sticky_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);

  always_ff @(posedge clk) begin
    if (rst)        q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end

  // R12: a set event wins over a same-cycle clear
  p_set_wins_r12: assert property (@(posedge clk) disable iff (rst)
    set_i |=> q_o);
  p_w1c_r12: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i) |=> !q_o);

endmodule

// File: rtl/fill_ctl.sv
module fill_ctl (
  input  logic clk,
  input  logic rst,
  input  logic mode_i,
  input  logic pat_i,
  input  logic wr_i,
  input  logic wbit_i,
  input  logic pclr_i,
  output logic det_o
);

  logic det_d;

  always_comb begin
    det_d = det_o;
    if (mode_i) begin
      if (wr_i) det_d = wbit_i;
    end else begin
      if (pat_i)                           det_d = 1'b1;
      else if ((wr_i && wbit_i) || pclr_i) det_d = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) det_o <= 1'b0;
    else     det_o <= det_d;
  end

  p_mode0_latch_r3: assert property (@(posedge clk) disable iff (rst)
    (!mode_i && pat_i) |=> det_o);
  p_mode1_follow_r4: assert property (@(posedge clk) disable iff (rst)
    (mode_i && wr_i) |=> (det_o == $past(wbit_i)));

endmodule

// File: rtl/lock_mon.sv
module lock_mon #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic lock_i,
  input  logic en_i,
  output logic rise_o,
  output logic pin_o
);

  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              lock_s;

  assign lock_s = sync_q[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
      pin_o  <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], lock_i};
      prev_q <= lock_s;
      pin_o  <= !en_i || lock_s;
    end
  end

  assign rise_o = lock_s && !prev_q;

  p_pin_forced_r10: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> pin_o);
  p_rise_once_r9: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o);

endmodule

// File: rtl/radio_stat_regs.sv
module radio_stat_regs
  import radio_stat_pkg::*;
#(
  parameter int             AW          = 8,
  parameter int             TW          = 8,
  parameter logic [AW-1:0]  STAT_ADDR   = 8'h0E,
  parameter logic [AW-1:0]  THLD_ADDR   = 8'h0F,
  parameter int             SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] bus_addr,
  input  logic [7:0]    bus_wdata,
  input  logic          bus_wr,
  output logic [7:0]    bus_rdata,
  input  logic          pkt_mode,
  input  logic          start_pat,
  input  logic          tx_last,
  input  logic          fifo_ovf,
  input  logic          pll_lock,
  input  logic [TW-1:0] rssi_val,
  output logic          fifo_clr,
  output logic          fill_en,
  output logic          lock_pin,
  output logic          irq
);

  localparam int RD_PAD = 8 - TW;

  stat_reg_t           wcmd;
  stat_reg_t           stat_rd;
  logic                wr_stat, wr_thld, pkt_clr;
  logic                fill_mode_q, ien_q, lock_en_q;
  logic [TW-1:0]       thld_q;
  logic                rssi_hit, lock_rise, start_det_q;
  logic [NUM_FLG-1:0]  set_v, clr_v, flag_q;

  assign wcmd    = stat_reg_t'(bus_wdata);
  assign wr_stat = bus_wr && (bus_addr == STAT_ADDR);
  assign wr_thld = bus_wr && (bus_addr == THLD_ADDR);
  assign pkt_clr = wr_stat && wcmd.ovf && pkt_mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      fill_mode_q <= STAT_RESET[7];
      ien_q       <= STAT_RESET[3];
      lock_en_q   <= STAT_RESET[0];
    end else if (wr_stat) begin
      fill_mode_q <= wcmd.fill_mode;
      ien_q       <= wcmd.rssi_ien;
      lock_en_q   <= wcmd.lock_en;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          thld_q <= '0;
    else if (wr_thld) thld_q <= bus_wdata[TW-1:0];
  end

  assign rssi_hit = (rssi_val >= thld_q);

  assign set_v[FLG_TX]   = tx_last;
  assign set_v[FLG_OVF]  = fifo_ovf;
  assign set_v[FLG_SIG]  = rssi_hit;
  assign set_v[FLG_LOCK] = lock_rise;

  assign clr_v[FLG_TX]   = (wr_stat && wcmd.tx_done) || pkt_clr;
  assign clr_v[FLG_OVF]  = wr_stat && wcmd.ovf;
  assign clr_v[FLG_SIG]  = wr_stat && wcmd.sig_det;
  assign clr_v[FLG_LOCK] = wr_stat && wcmd.lock_seen;

  for (genvar gi = 0; gi < NUM_FLG; gi++) begin : g_flag
    sticky_flag u_flag (
      .clk   (clk),
      .rst   (rst),
      .set_i (set_v[gi]),
      .clr_i (clr_v[gi]),
      .q_o   (flag_q[gi])
    );
  end

  fill_ctl u_fill (
    .clk    (clk),
    .rst    (rst),
    .mode_i (fill_mode_q),
    .pat_i  (start_pat),
    .wr_i   (wr_stat),
    .wbit_i (wcmd.start_det),
    .pclr_i (pkt_clr),
    .det_o  (start_det_q)
  );

  lock_mon #(.STAGES(SYNC_STAGES)) u_lock (
    .clk    (clk),
    .rst    (rst),
    .lock_i (pll_lock),
    .en_i   (lock_en_q),
    .rise_o (lock_rise),
    .pin_o  (lock_pin)
  );

  always_comb begin
    stat_rd.fill_mode = fill_mode_q;
    stat_rd.start_det = start_det_q;
    stat_rd.tx_done   = flag_q[FLG_TX];
    stat_rd.ovf       = flag_q[FLG_OVF];
    stat_rd.rssi_ien  = ien_q;
    stat_rd.sig_det   = flag_q[FLG_SIG];
    stat_rd.lock_seen = flag_q[FLG_LOCK];
    stat_rd.lock_en   = lock_en_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      fifo_clr  <= 1'b0;
    end else begin
      fifo_clr <= wr_stat && wcmd.ovf;
      if (bus_addr == STAT_ADDR)      bus_rdata <= stat_rd;
      else if (bus_addr == THLD_ADDR) bus_rdata <= {{RD_PAD{1'b0}}, thld_q};
      else                            bus_rdata <= '0;
    end
  end

  assign fill_en = start_det_q;
  assign irq     = flag_q[FLG_SIG] && ien_q;

  p_rssi_hit_r8: assert property (@(posedge clk) disable iff (rst)
    rssi_hit |=> flag_q[FLG_SIG]);
  p_clr_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_stat && wcmd.ovf) |=> fifo_clr);
  p_pkt_rearm_r7: assert property (@(posedge clk) disable iff (rst)
    (pkt_clr && !tx_last) |=> !flag_q[FLG_TX]);
  p_irq_src_r11: assert property (@(posedge clk) disable iff (rst)
    irq |-> (stat_rd.sig_det && stat_rd.rssi_ien));

endmodule

// File: tb/sim_radio_stat_regs.sv
`timescale 1ns/1ps
module sim_radio_stat_regs;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] bus_addr = 8'h00;
  logic [7:0] bus_wdata = 8'h00;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_rdata;
  logic       pkt_mode = 1'b0, start_pat = 1'b0, tx_last = 1'b0, fifo_ovf = 1'b0;
  logic       pll_lock = 1'b0;
  logic [7:0] rssi_val = 8'h00;
  logic       fifo_clr, fill_en, lock_pin, irq;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  radio_stat_regs u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rdata(bus_rdata), .pkt_mode(pkt_mode),
    .start_pat(start_pat), .tx_last(tx_last), .fifo_ovf(fifo_ovf),
    .pll_lock(pll_lock), .rssi_val(rssi_val), .fifo_clr(fifo_clr),
    .fill_en(fill_en), .lock_pin(lock_pin), .irq(irq)
  );

  // bench model state
  logic [7:0] m_stat, m_thld, m_rd;
  logic [1:0] m_sync;
  logic       m_prev, m_pin, m_clr;

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic model_step();
    logic [7:0] c, n;
    logic wrs, wrt, pkc, rise;
    c = m_stat; n = m_stat;
    if (rst) begin
      m_stat = 8'h01; m_thld = 8'h00; m_rd = 8'h00; m_sync = 2'b00;
      m_prev = 1'b0; m_pin = 1'b0; m_clr = 1'b0;
    end else begin
      wrs  = bus_wr && bus_addr == 8'h0E;
      wrt  = bus_wr && bus_addr == 8'h0F;
      pkc  = wrs && bus_wdata[4] && pkt_mode;
      rise = m_sync[1] && !m_prev;
      if (wrs) begin n[7] = bus_wdata[7]; n[3] = bus_wdata[3]; n[0] = bus_wdata[0]; end
      if (c[7]) n[6] = wrs ? bus_wdata[6] : c[6];
      else      n[6] = start_pat ? 1'b1 : (((wrs && bus_wdata[6]) || pkc) ? 1'b0 : c[6]);
      n[5] = tx_last ? 1'b1 : (((wrs && bus_wdata[5]) || pkc) ? 1'b0 : c[5]);
      n[4] = fifo_ovf ? 1'b1 : ((wrs && bus_wdata[4]) ? 1'b0 : c[4]);
      n[2] = (rssi_val >= m_thld) ? 1'b1 : ((wrs && bus_wdata[2]) ? 1'b0 : c[2]);
      n[1] = rise ? 1'b1 : ((wrs && bus_wdata[1]) ? 1'b0 : c[1]);
      m_pin  = !c[0] || m_sync[1];
      m_prev = m_sync[1];
      m_sync = {m_sync[0], pll_lock};
      m_clr  = wrs && bus_wdata[4];
      m_rd   = (bus_addr == 8'h0E) ? c : ((bus_addr == 8'h0F) ? m_thld : 8'h00);
      if (wrt) m_thld = bus_wdata;
      m_stat = n;
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk("R2 rdata", bus_rdata, m_rd);
    chk("R6 fifo_clr", {7'd0, fifo_clr}, {7'd0, m_clr});
    chk("R3 fill_en", {7'd0, fill_en}, {7'd0, m_stat[6]});
    chk("R10 lock_pin", {7'd0, lock_pin}, {7'd0, m_pin});
    chk("R11 irq", {7'd0, irq}, {7'd0, m_stat[2] & m_stat[3]});
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    cyc();
    bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [7:0] v);
    bus_addr = a; bus_wr = 1'b0;
    cyc();
    v = bus_rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd1234));
    @(negedge clk);
    cyc(); cyc();
    // R1: reset state of outputs
    chk("R1 rdata", bus_rdata, 8'h00);
    chk("R1 fill_en", {7'd0, fill_en}, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);
    chk("R1 fifo_clr", {7'd0, fifo_clr}, 8'h00);
    chk("R1 lock_pin", {7'd0, lock_pin}, 8'h00);
    rst = 1'b0;
    rd_reg(8'h0E, v); chk("R1 stat reset", v, 8'h01);
    rd_reg(8'h0F, v); chk("R1 thld reset", v, 8'h00);

    // R2: threshold store, unmapped address
    wr_reg(8'h0F, 8'h80);
    rd_reg(8'h0F, v); chk("R2 thld write", v, 8'h80);
    wr_reg(8'h10, 8'hFF);
    rd_reg(8'h10, v); chk("R2 unmapped", v, 8'h00);
    rd_reg(8'h0F, v); chk("R2 thld kept", v, 8'h80);

    // R8: threshold boundary
    wr_reg(8'h0E, 8'h05);
    rssi_val = 8'h7F; cyc(); cyc();
    rd_reg(8'h0E, v); chk("R8 below thld", {7'd0, v[2]}, 8'h00);
    rssi_val = 8'h80; cyc(); rssi_val = 8'h00;
    cyc(); cyc();
    rd_reg(8'h0E, v); chk("R8 equal sticky", {7'd0, v[2]}, 8'h01);

    // R11: interrupt gating
    wr_reg(8'h0E, 8'h09); chk("R11 irq on", {7'd0, irq}, 8'h01);
    wr_reg(8'h0E, 8'h0D); chk("R11 irq cleared", {7'd0, irq}, 8'h00);

    // R12: set and clear in the same cycle
    rssi_val = 8'h90;
    wr_reg(8'h0E, 8'h0D); chk("R12 set wins", {7'd0, irq}, 8'h01);
    rssi_val = 8'h00;
    wr_reg(8'h0E, 8'h05);

    // R3: mode 0 latch
    start_pat = 1'b1; cyc(); start_pat = 1'b0;
    chk("R3 latch", {7'd0, fill_en}, 8'h01);
    cyc(); cyc(); chk("R3 hold", {7'd0, fill_en}, 8'h01);
    wr_reg(8'h0E, 8'h41); chk("R3 w1c", {7'd0, fill_en}, 8'h00);

    // R4: mode 1 level
    wr_reg(8'h0E, 8'h81);
    start_pat = 1'b1; cyc(); start_pat = 1'b0;
    chk("R4 pattern ignored", {7'd0, fill_en}, 8'h00);
    wr_reg(8'h0E, 8'hC1); chk("R4 write 1", {7'd0, fill_en}, 8'h01);
    wr_reg(8'h0E, 8'h81); chk("R4 write 0", {7'd0, fill_en}, 8'h00);
    wr_reg(8'h0E, 8'h01);

    // R5: transmit done flag
    tx_last = 1'b1; cyc(); tx_last = 1'b0;
    rd_reg(8'h0E, v); chk("R5 set", {7'd0, v[5]}, 8'h01);
    wr_reg(8'h0E, 8'h21);
    rd_reg(8'h0E, v); chk("R5 clear", {7'd0, v[5]}, 8'h00);

    // R6/R7: overflow clear, buffered then packet mode
    fifo_ovf = 1'b1; cyc(); fifo_ovf = 1'b0;
    rd_reg(8'h0E, v); chk("R6 ovf set", {7'd0, v[4]}, 8'h01);
    start_pat = 1'b1; tx_last = 1'b1; cyc(); start_pat = 1'b0; tx_last = 1'b0;
    pkt_mode = 1'b0;
    wr_reg(8'h0E, 8'h11);
    chk("R6 clr pulse", {7'd0, fifo_clr}, 8'h01);
    chk("R7 buffered keeps fill", {7'd0, fill_en}, 8'h01);
    cyc(); chk("R6 pulse ends", {7'd0, fifo_clr}, 8'h00);
    rd_reg(8'h0E, v);
    chk("R6 ovf cleared", {7'd0, v[4]}, 8'h00);
    chk("R7 buffered keeps tx", {7'd0, v[5]}, 8'h01);
    pkt_mode = 1'b1;
    wr_reg(8'h0E, 8'h11); chk("R7 packet clears fill", {7'd0, fill_en}, 8'h00);
    pkt_mode = 1'b0;
    rd_reg(8'h0E, v); chk("R7 packet clears tx", {7'd0, v[5]}, 8'h00);

    // R9/R10: lock latch and pin
    wr_reg(8'h0E, 8'h00); cyc();
    chk("R10 forced high", {7'd0, lock_pin}, 8'h01);
    pll_lock = 1'b1; repeat (4) cyc();
    rd_reg(8'h0E, v); chk("R9 rise latched", {7'd0, v[1]}, 8'h01);
    wr_reg(8'h0E, 8'h03); repeat (3) cyc();
    chk("R10 follows high", {7'd0, lock_pin}, 8'h01);
    rd_reg(8'h0E, v); chk("R9 no reset while held", {7'd0, v[1]}, 8'h00);
    pll_lock = 1'b0; repeat (4) cyc();
    chk("R10 follows low", {7'd0, lock_pin}, 8'h00);

    // random phase, R12 collisions included, judged by the model
    for (int i = 0; i < 4000; i++) begin
      bus_wr    = ($urandom_range(3) == 0);
      case ($urandom_range(3))
        0, 1:    bus_addr = 8'h0E;
        2:       bus_addr = 8'h0F;
        default: bus_addr = 8'($urandom);
      endcase
      bus_wdata = 8'($urandom);
      pkt_mode  = 1'($urandom);
      start_pat = ($urandom_range(7) == 0);
      tx_last   = ($urandom_range(7) == 0);
      fifo_ovf  = ($urandom_range(7) == 0);
      if ($urandom_range(15) == 0) pll_lock = ~pll_lock;
      rssi_val  = 8'($urandom);
      cyc();
    end
    bus_wr = 1'b0;

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule